// File: doc/BRIEF.md
# Security-Tagged Cache Lookup Array

This block is the tag and data store of a small set-associative cache in which every line remembers the security attribute of the access that installed it. The attribute is treated as one more address bit. A secure copy and a non-secure copy of the same address are therefore two different lines. They can sit side by side in a set, and a lookup only finds the copy whose attribute matches. When the processor changes between the secure and the normal world, nothing is flushed.

A lookup port accepts an address and an attribute and returns, one cycle later, the hit flag, the way that hit and the line data. A separate fill port installs a line, with data supplied from outside, in the cycle it is presented. Two maintenance inputs clear every line at once or clear the single line that matches an address and attribute pair. A world input marks the requester as the normal world. While it is high, every request behaves as non-secure, whatever attribute it carries.

Top module: `sec_tag_cache`

## Requirements
- R1: While rst is high and in the cycle after it falls, rsp_valid is 0. Every line is invalid after reset, so the first lookups miss.
- R2: rsp_valid equals req_valid of the previous cycle. The result reflects the array as it stood before the clock edge that samples the request, so a fill presented in the same cycle is not seen.
- R3: A fill presented in cycle t is installed at the end of that cycle. A lookup in cycle t+1 with the same address and effective attribute hits and returns the fill data.
- R4: A lookup hits only when the line is valid and both the tag and the stored attribute equal the request. A non-secure lookup of a secure line misses, and a secure lookup of a non-secure line misses.
- R5: While world_ns is 1, the effective attribute of lookups, fills and single-line invalidations is 1 (non-secure), whatever req_ns, fill_ns or inv_ns carry. While world_ns is 0, the effective attribute is the request's own bit (1 = non-secure).
- R6: A fill whose address is already held with the other attribute never overwrites that line. Both copies stay resident and each returns its own data.
- R7: A change of world_ns invalidates no line. Lines filled before the change still hit afterwards.
- R8: inv_all clears every line at the end of its cycle. A fill or single-line invalidation in the same cycle is dropped.
- R9: inv_one clears only the line whose tag, set and stored attribute match inv_addr and the effective inv_ns. A fill in the same cycle is applied after the clear, so that fill's line is valid afterwards.
- R10: The fill way is chosen in this order. First, a valid way holding the same tag and attribute, which is overwritten in place. Next, the lowest-numbered invalid way. Otherwise, the set's round-robin pointer, which is 0 after reset; if that way holds the same tag with the other attribute, the next way is used instead. Only an eviction moves the pointer, to the way after the victim.
- R11: On a miss, rsp_hit is 0 and rsp_way and rsp_data are 0.
- R12: On a hit, rsp_way is the number of the way that holds the line and rsp_data is its stored data. The set index is addr[IDX_W-1:0] and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| world_ns | input | 1 | 1 while the requester runs in the normal world |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Lookup address |
| req_ns | input | 1 | Lookup attribute, 1 = non-secure |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Fill address |
| fill_ns | input | 1 | Fill attribute, 1 = non-secure |
| fill_data | input | DATA_W | Line data to install |
| inv_all | input | 1 | Invalidate every line |
| inv_one | input | 1 | Invalidate one line by address and attribute |
| inv_addr | input | ADDR_W | Address for inv_one |
| inv_ns | input | 1 | Attribute for inv_one |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Way that hit |
| rsp_data | output | DATA_W | Data of the line that hit |

## Verification
The sharpest overlap is a lookup and a fill, or a fill and an invalidation, landing on the same set in one cycle. The lookup must report the array as it was before the edge. A clear and a fill of the same line must leave the fill standing, and a full clear must swallow the fill. Directed cycles drive each of these pairs on one address, and a random phase on a narrow address pool makes them collide often. A bench model, applying the requirement ordering of clear before write, judges every response for hit, way and data.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [1:0] {
        PICK_REFRESH = 2'd0,
        PICK_FREE    = 2'd1,
        PICK_EVICT   = 2'd2
    } fill_pick_e;

    // lowest set bit position of a vector, 0 when empty
    function automatic int first_one(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    // circular successor of a way number
    function automatic int next_way(input int w, input int n);
        return (w + 1 >= n) ? 0 : w + 1;
    endfunction

endpackage

// File: rtl/stc_way_store.sv
module stc_way_store #(
    parameter int SETS   = 8,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_ns,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  fl_idx,
    input  logic [TAG_W-1:0]  fl_tag,
    input  logic              fl_ns,
    output logic              fl_same,
    output logic              fl_twin,
    output logic              fl_free,
    input  logic              iv_en,
    input  logic [IDX_W-1:0]  iv_idx,
    input  logic [TAG_W-1:0]  iv_tag,
    input  logic              iv_ns,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_ns,
    input  logic [DATA_W-1:0] wr_data
);
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   ns_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];
    logic              iv_match;

    always_comb begin
        lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && (ns_q[lk_idx] == lk_ns);
        lk_data  = data_q[lk_idx];
        fl_free  = !valid_q[fl_idx];
        fl_same  = valid_q[fl_idx] && (tag_q[fl_idx] == fl_tag) && (ns_q[fl_idx] == fl_ns);
        fl_twin  = valid_q[fl_idx] && (tag_q[fl_idx] == fl_tag) && (ns_q[fl_idx] != fl_ns);
        iv_match = iv_en && valid_q[iv_idx] && (tag_q[iv_idx] == iv_tag) && (ns_q[iv_idx] == iv_ns);
    end

    // valid bits: clear, then targeted clear, then fill (later wins)
    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            valid_q <= '0;
        end else begin
            if (iv_match) valid_q[iv_idx] <= 1'b0;
            if (wr_en)    valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q <= '0;
        end else if (wr_en) begin
            ns_q[wr_idx] <= wr_ns;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/stc_fill_pick.sv
module stc_fill_pick
    import stc_pkg::*;
#(
    parameter int WAYS   = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  same_vec,
    input  logic [WAYS-1:0]  twin_vec,
    input  logic [WAYS-1:0]  free_vec,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] pick_way,
    output fill_pick_e       pick_kind,
    output logic [WAY_W-1:0] rr_next
);
    logic [WAY_W-1:0] victim;

    always_comb begin
        victim = rr_ptr;
        if (twin_vec[rr_ptr]) victim = WAY_W'(next_way(int'(rr_ptr), WAYS));

        if (|same_vec) begin
            pick_kind = PICK_REFRESH;
            pick_way  = WAY_W'(first_one(32'(same_vec)));
        end else if (|free_vec) begin
            pick_kind = PICK_FREE;
            pick_way  = WAY_W'(first_one(32'(free_vec)));
        end else begin
            pick_kind = PICK_EVICT;
            pick_way  = victim;
        end
        rr_next = WAY_W'(next_way(int'(victim), WAYS));
    end

endmodule

// File: rtl/stc_rr_table.sv
module stc_rr_table #(
    parameter int SETS   = 8,
    parameter int WAYS   = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WAY_W-1:0] rd_ptr,
    input  logic             adv_en,
    input  logic [IDX_W-1:0] adv_idx,
    input  logic [WAY_W-1:0] adv_val
);
    logic [WAY_W-1:0] ptr_q [SETS];

    assign rd_ptr = ptr_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv_en) begin
            ptr_q[adv_idx] <= adv_val;
        end
    end

endmodule

// File: rtl/sec_tag_cache.sv
module sec_tag_cache
    import stc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    parameter int WAYS   = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              world_ns,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ns,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ns,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inv_all,
    input  logic              inv_one,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              inv_ns,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [DATA_W-1:0] rsp_data
);
    // effective attributes: normal world always non-secure
    logic lk_ns_eff, fl_ns_eff, iv_ns_eff;
    assign lk_ns_eff = req_ns  | world_ns;
    assign fl_ns_eff = fill_ns | world_ns;
    assign iv_ns_eff = inv_ns  | world_ns;

    logic [IDX_W-1:0] lk_idx, fl_idx, iv_idx;
    logic [TAG_W-1:0] lk_tag, fl_tag, iv_tag;
    assign lk_idx = req_addr[IDX_W-1:0];
    assign lk_tag = req_addr[ADDR_W-1:IDX_W];
    assign fl_idx = fill_addr[IDX_W-1:0];
    assign fl_tag = fill_addr[ADDR_W-1:IDX_W];
    assign iv_idx = inv_addr[IDX_W-1:0];
    assign iv_tag = inv_addr[ADDR_W-1:IDX_W];

    logic [WAYS-1:0]   lk_hit_vec, same_vec, twin_vec, free_vec, wr_vec;
    logic [DATA_W-1:0] lk_data [WAYS];

    logic             fill_go, iv_go;
    logic [WAY_W-1:0] pick_way, rr_ptr, rr_next;
    fill_pick_e       pick_kind;

    assign fill_go = fill_valid && !inv_all;
    assign iv_go   = inv_one && !inv_all;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            wr_vec[w] = fill_go && (int'(pick_way) == w);
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        stc_way_store #(
            .SETS  (SETS),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_store (
            .clk    (clk),
            .rst    (rst),
            .clr_all(inv_all),
            .lk_idx (lk_idx),
            .lk_tag (lk_tag),
            .lk_ns  (lk_ns_eff),
            .lk_hit (lk_hit_vec[w]),
            .lk_data(lk_data[w]),
            .fl_idx (fl_idx),
            .fl_tag (fl_tag),
            .fl_ns  (fl_ns_eff),
            .fl_same(same_vec[w]),
            .fl_twin(twin_vec[w]),
            .fl_free(free_vec[w]),
            .iv_en  (iv_go),
            .iv_idx (iv_idx),
            .iv_tag (iv_tag),
            .iv_ns  (iv_ns_eff),
            .wr_en  (wr_vec[w]),
            .wr_idx (fl_idx),
            .wr_tag (fl_tag),
            .wr_ns  (fl_ns_eff),
            .wr_data(fill_data)
        );
    end

    stc_rr_table #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_rr (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (fl_idx),
        .rd_ptr (rr_ptr),
        .adv_en (fill_go && (pick_kind == PICK_EVICT)),
        .adv_idx(fl_idx),
        .adv_val(rr_next)
    );

    stc_fill_pick #(
        .WAYS(WAYS)
    ) u_pick (
        .same_vec (same_vec),
        .twin_vec (twin_vec),
        .free_vec (free_vec),
        .rr_ptr   (rr_ptr),
        .pick_way (pick_way),
        .pick_kind(pick_kind),
        .rr_next  (rr_next)
    );

    // hit selection: at most one way holds a given tag and attribute
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [DATA_W-1:0] hit_data;

    always_comb begin
        any_hit  = |lk_hit_vec;
        hit_way  = WAY_W'(first_one(32'(lk_hit_vec)));
        hit_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_data = hit_data | (lk_data[w] & {DATA_W{lk_hit_vec[w]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && any_hit;
            rsp_way   <= (req_valid && any_hit) ? hit_way : '0;
            rsp_data  <= (req_valid && any_hit) ? hit_data : '0;
        end
    end

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int WAY_W  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              world_ns,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ns,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_ns,
    input logic [DATA_W-1:0] fill_data,
    input logic              inv_all,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [DATA_W-1:0] rsp_data
);
    logic              lf_ok;
    logic [ADDR_W-1:0] lf_addr;
    logic              lf_ns;
    logic [DATA_W-1:0] lf_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            lf_ok   <= 1'b0;
            lf_addr <= '0;
            lf_ns   <= 1'b0;
            lf_data <= '0;
        end else begin
            lf_ok   <= fill_valid && !inv_all;
            lf_addr <= fill_addr;
            lf_ns   <= fill_ns | world_ns;
            lf_data <= fill_data;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R2
    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && rsp_way == '0)); // R11
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) ($past(rst) && req_valid) |=> !rsp_hit); // R1
    AST_EMPTY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst) ($past(inv_all) && req_valid) |=> !rsp_hit); // R8
    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (lf_ok && req_valid && req_addr == lf_addr && (req_ns | world_ns) == lf_ns)
        |=> (rsp_hit && rsp_data == $past(lf_data))); // R3

endmodule

bind sec_tag_cache stc_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WAY_W (WAY_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .world_ns  (world_ns),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ns    (req_ns),
    .fill_valid(fill_valid),
    .fill_addr (fill_addr),
    .fill_ns   (fill_ns),
    .fill_data (fill_data),
    .inv_all   (inv_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way),
    .rsp_data  (rsp_data)
);

// File: tb/sec_tag_cache_tb_top.sv
module sec_tag_cache_tb_top;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int SETS   = 8;
    localparam int WAYS   = 2;
    localparam int IDX_W  = 3;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int WAY_W  = 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst, world_ns, req_valid, req_ns, fill_valid, fill_ns;
    logic              inv_all, inv_one, inv_ns;
    logic [ADDR_W-1:0] req_addr, fill_addr, inv_addr;
    logic [DATA_W-1:0] fill_data;
    logic              rsp_valid, rsp_hit;
    logic [WAY_W-1:0]  rsp_way;
    logic [DATA_W-1:0] rsp_data;

    sec_tag_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst(rst), .world_ns(world_ns),
        .req_valid(req_valid), .req_addr(req_addr), .req_ns(req_ns),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_ns(fill_ns), .fill_data(fill_data),
        .inv_all(inv_all), .inv_one(inv_one), .inv_addr(inv_addr), .inv_ns(inv_ns),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference state built from the requirements
    bit                m_v   [SETS][WAYS];
    bit                m_ns  [SETS][WAYS];
    logic [TAG_W-1:0]  m_tag [SETS][WAYS];
    logic [DATA_W-1:0] m_dat [SETS][WAYS];
    int                m_rr  [SETS];

    typedef struct packed {
        logic              world;
        logic              rv;
        logic [ADDR_W-1:0] ra;
        logic              rns;
        logic              fv;
        logic [ADDR_W-1:0] fa;
        logic              fns;
        logic [DATA_W-1:0] fd;
        logic              ia;
        logic              io;
        logic [ADDR_W-1:0] iaddr;
        logic              ins;
    } op_t;

    function automatic op_t lookup(input logic [ADDR_W-1:0] a, input logic ns, input logic world);
        op_t o = '0;
        o.rv = 1'b1; o.ra = a; o.rns = ns; o.world = world;
        return o;
    endfunction

    function automatic op_t fill(input logic [ADDR_W-1:0] a, input logic ns, input logic [DATA_W-1:0] d,
                                 input logic world);
        op_t o = '0;
        o.fv = 1'b1; o.fa = a; o.fns = ns; o.fd = d; o.world = world;
        return o;
    endfunction

    function automatic int pick_way(input int s, input logic [TAG_W-1:0] t, input bit n, output bit evict);
        int v;
        evict = 1'b0;
        for (int w = 0; w < WAYS; w++) if (m_v[s][w] && m_tag[s][w] == t && m_ns[s][w] == n) return w;
        for (int w = 0; w < WAYS; w++) if (!m_v[s][w]) return w;
        evict = 1'b1;
        v = m_rr[s];
        if (m_v[s][v] && m_tag[s][v] == t && m_ns[s][v] != n) v = (v + 1) % WAYS;
        return v;
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // drive one cycle (called at a falling edge), then check the response
    task automatic cyc(input op_t o, input string tag);
        bit eh, evict, n;
        int ew, fw, s;
        logic [DATA_W-1:0] ed;
        world_ns = o.world; req_valid = o.rv; req_addr = o.ra; req_ns = o.rns;
        fill_valid = o.fv; fill_addr = o.fa; fill_ns = o.fns; fill_data = o.fd;
        inv_all = o.ia; inv_one = o.io; inv_addr = o.iaddr; inv_ns = o.ins;
        eh = 0; ew = 0; ed = '0;
        if (o.rv) begin
            s = int'(o.ra[IDX_W-1:0]); n = o.rns | o.world;
            for (int w = 0; w < WAYS; w++)
                if (m_v[s][w] && m_tag[s][w] == o.ra[ADDR_W-1:IDX_W] && m_ns[s][w] == n) begin
                    eh = 1; ew = w; ed = m_dat[s][w];
                end
        end
        if (o.ia) begin
            for (int i = 0; i < SETS; i++) for (int w = 0; w < WAYS; w++) m_v[i][w] = 0;
        end else begin
            fw = 0; evict = 0;
            if (o.fv) fw = pick_way(int'(o.fa[IDX_W-1:0]), o.fa[ADDR_W-1:IDX_W], o.fns | o.world, evict);
            if (o.io) begin
                s = int'(o.iaddr[IDX_W-1:0]); n = o.ins | o.world;
                for (int w = 0; w < WAYS; w++)
                    if (m_v[s][w] && m_tag[s][w] == o.iaddr[ADDR_W-1:IDX_W] && m_ns[s][w] == n) m_v[s][w] = 0;
            end
            if (o.fv) begin
                s = int'(o.fa[IDX_W-1:0]);
                m_v[s][fw] = 1; m_ns[s][fw] = o.fns | o.world;
                m_tag[s][fw] = o.fa[ADDR_W-1:IDX_W]; m_dat[s][fw] = o.fd;
                if (evict) m_rr[s] = (fw + 1) % WAYS;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "rsp_valid", 64'(rsp_valid), 64'(o.rv));
        if (o.rv) begin
            check(tag, "rsp_hit", 64'(rsp_hit), 64'(eh));
            check(tag, "rsp_way", 64'(rsp_way), 64'(ew));
            check(tag, "rsp_data", 64'(rsp_data), 64'(ed));
        end
    endtask

    task automatic run_all();
        op_t o;
        localparam logic [ADDR_W-1:0] A = 12'h015, B = 12'h023;
        localparam logic [ADDR_W-1:0] C = 12'h02D, D = 12'h035, E = 12'h03D;
        localparam logic [ADDR_W-1:0] X = 12'h016, Y = 12'h01E;
        void'($urandom(32'd1234));
        for (int i = 0; i < SETS; i++) begin
            m_rr[i] = 0;
            for (int w = 0; w < WAYS; w++) m_v[i][w] = 0;
        end
        rst = 1'b1;
        o = '0;
        world_ns = 0; req_valid = 0; req_addr = 0; req_ns = 0; fill_valid = 0; fill_addr = 0;
        fill_ns = 0; fill_data = 0; inv_all = 0; inv_one = 0; inv_addr = 0; inv_ns = 0;
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;
        cyc(lookup(A, 0, 0), "R1");
        // same-cycle lookup and fill: lookup sees the old state
        o = fill(A, 0, 32'hAAAA_0001, 0); o.rv = 1; o.ra = A; o.rns = 0;
        cyc(o, "R2");
        cyc(lookup(A, 0, 0), "R3");
        cyc(lookup(A, 1, 0), "R4");
        cyc(fill(A, 1, 32'h5555_0002, 0), "R6");
        cyc(lookup(A, 1, 0), "R6");
        cyc(lookup(A, 0, 0), "R6");
        cyc(lookup(A, 0, 1), "R5");
        cyc(lookup(A, 0, 0), "R7");
        cyc(fill(B, 0, 32'h0B0B_0003, 1), "R5");
        cyc(lookup(B, 0, 0), "R5");
        cyc(lookup(B, 1, 0), "R5");
        o = '0; o.io = 1; o.iaddr = A; o.ins = 1;
        cyc(o, "R9");
        cyc(lookup(A, 1, 0), "R9");
        cyc(lookup(A, 0, 0), "R9");
        cyc(fill(C, 0, 32'hC0C0_0004, 0), "R10");
        cyc(fill(D, 0, 32'hD0D0_0005, 0), "R10");
        cyc(fill(E, 0, 32'hE0E0_0006, 0), "R10");
        cyc(lookup(C, 0, 0), "R10");
        cyc(lookup(D, 0, 0), "R10");
        cyc(lookup(E, 0, 0), "R12");
        cyc(fill(X, 0, 32'h1111_0007, 0), "R10");
        cyc(fill(Y, 0, 32'h2222_0008, 0), "R10");
        cyc(fill(X, 1, 32'h3333_0009, 0), "R6");
        cyc(lookup(X, 0, 0), "R6");
        cyc(lookup(X, 1, 0), "R6");
        cyc(lookup(Y, 0, 0), "R10");
        cyc(fill(X, 0, 32'h4444_000A, 0), "R10");
        cyc(lookup(X, 0, 0), "R10");
        o = fill(B, 0, 32'hBEEF_000B, 0); o.io = 1; o.iaddr = B; o.ins = 0;
        cyc(o, "R9");
        cyc(lookup(B, 0, 0), "R9");
        o = fill(A, 0, 32'hF00D_000C, 0); o.ia = 1;
        cyc(o, "R8");
        cyc(lookup(A, 0, 0), "R8");
        cyc(lookup(X, 1, 0), "R8");
        // mixed random phase on a narrow address pool
        for (int i = 0; i < 4000; i++) begin
            logic [ADDR_W-1:0] ra, fa, ia;
            o = '0;
            ra = {ADDR_W'($urandom_range(0, 2)), 3'($urandom_range(0, 3))} << 0;
            ra = ADDR_W'(($urandom_range(0, 2) << IDX_W) | $urandom_range(0, 3));
            fa = ADDR_W'(($urandom_range(0, 2) << IDX_W) | $urandom_range(0, 3));
            ia = ADDR_W'(($urandom_range(0, 2) << IDX_W) | $urandom_range(0, 3));
            o.world = ($urandom_range(0, 3) == 0);
            o.rv = ($urandom_range(0, 3) != 0); o.ra = ra; o.rns = 1'($urandom);
            o.fv = ($urandom_range(0, 2) == 0); o.fa = fa; o.fns = 1'($urandom); o.fd = $urandom;
            o.io = ($urandom_range(0, 7) == 0); o.iaddr = ia; o.ins = 1'($urandom);
            o.ia = ($urandom_range(0, 199) == 0);
            cyc(o, "random R4");
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule